// File: doc/BRIEF.md
# Segmented Command and Data Port with Persistent Routing

This block is the 16-bit host port of a memory whose internal resources are 64 bits wide. Each cycle the host presents chip-enable, write-enable and command-enable together with a data word. Command cycles reach an instruction decoder on a write and the status word on a read. Data cycles reach whichever resource is currently chosen as the persistent data source or data destination. These two choices are sticky. They are changed only by dedicated instructions.

A one-shot override instruction redirects only the next command cycle to one of six small configuration registers, or to a readback of the persistent selections. A 64-bit resource is transferred as four 16-bit segments. Separate source and destination segment counters step through the segments automatically. Two banks of routing and control registers, foreground and background, can be swapped with a single instruction. The comparison array is not part of this block. Plain registers stand in for the comparand, the two masks and a small memory.

Top module: `seg_route_port`

## Requirements
- R1: After reset the foreground bank is active. Both persistent selections are the comparand (code 0). Both segment counters are 0. A command read with no override pending returns the status word, which is 0 after reset.
- R2: Segment k of a 64-bit resource is bits 16k+15 down to 16k. Four consecutive data writes from counter 0 fill segments 0 to 3. Four consecutive data reads from counter 0 return them in the same order.
- R3: The destination counter advances by one after each data write. The source counter advances by one after each data read. Each wraps from 3 to 0. The status word shows the source counter in bits 1:0 and the destination counter in bits 3:2.
- R4: A command word with bits 15:12 = 1 sets the persistent source to bits 1:0. A command word with bits 15:12 = 2 sets the persistent destination to bits 1:0. The codes are 0 comparand, 1 mask 1, 2 mask 2, 3 memory word. Each choice is independent of the other and holds until the next such instruction. Status bits 6:5 show the source and bits 8:7 show the destination.
- R5: Executing a source-select instruction clears the source counter. Executing a destination-select instruction clears the destination counter.
- R6: A command word with bits 15:12 = 3 arms an override for target bits 2:0. The targets are 0 control, 1 page address, 2 segment control, 3 address, 4 next-free address and 5 device select. The next command cycle, read or write, accesses that target instead of the default. Data cycles in between do not consume the override. After that one command cycle the default routing returns.
- R7: Override targets 6 and 7 return the persistent source and the persistent destination of the active bank on a read. A write to either one is ignored.
- R8: Control, segment control, address, mask 1 and both persistent selections exist once per bank. Page address, next-free address, device select, comparand, mask 2 and the memory are shared by both banks.
- R9: Command 4 selects the foreground bank and command 5 selects the background bank. Status bit 4 is 1 while the background bank is active. A bank selection clears both segment counters.
- R10: The memory word resource is the entry indexed by the active bank's address register, low 4 bits.
- R11: A cycle with chip-enable low changes no state and leaves the data output unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ce | input | 1 | Cycle enable |
| we | input | 1 | 1 = write cycle, 0 = read cycle |
| cmd | input | 1 | 1 = command cycle, 0 = data cycle |
| din | input | 16 | Write data or instruction word |
| dout | output | 16 | Read data, registered, valid the cycle after a read |

## Verification
The hardest situation to reach is an override left armed while data cycles pass through. The bench must show that those data cycles neither consume the override nor get redirected by it. It must then show that exactly one command cycle is spent on the override. The bench arms an override, streams data writes to the comparand and then spends the override on a command write. It reads the target back through a second override. Finally it confirms that the following command write is decoded as an instruction again. Bank separation is shown by programming different values into both copies of the banked state, including two different memory addresses. The bench then switches back and forth and reads every copy back.

// File: rtl/seg_route_port.sv
module seg_route_port #(
  parameter int DW    = 16,
  parameter int SEGS  = 4,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce,
  input  logic          we,
  input  logic          cmd,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  localparam int WW = DW * SEGS;
  localparam int AW = $clog2(DEPTH);
  localparam int SW = $clog2(SEGS);
  localparam logic [3:0] OP_SPS = 4'd1, OP_SPD = 4'd2, OP_TCO = 4'd3,
                         OP_SFG = 4'd4, OP_SBG = 4'd5;
  localparam logic [1:0] SEL_CMP = 2'd0, SEL_M1 = 2'd1, SEL_M2 = 2'd2, SEL_MEM = 2'd3;

  logic          bank;
  logic [1:0]    ps_q   [2];
  logic [1:0]    pd_q   [2];
  logic [DW-1:0] ctl_q  [2];
  logic [DW-1:0] sctl_q [2];
  logic [AW-1:0] adr_q  [2];
  logic [WW-1:0] m1_q   [2];
  logic [DW-1:0] page_q, nfa_q, dsel_q;
  logic [WW-1:0] cmp_q, m2_q;
  logic [WW-1:0] mem_q  [DEPTH];
  logic [SW-1:0] src_seg, dst_seg;
  logic          tco_pend;
  logic [2:0]    tco_tgt;

  wire dwr = ce & we & ~cmd;
  wire drd = ce & ~we & ~cmd;
  wire cwr = ce & we & cmd;
  wire crd = ce & ~we & cmd;
  wire [3:0] op = din[DW-1 -: 4];
  wire instr = cwr & ~tco_pend;

  wire [1:0]    ps_a = ps_q[bank];
  wire [1:0]    pd_a = pd_q[bank];
  wire [AW-1:0] adr_a = adr_q[bank];

  wire [SW-1:0] src_nxt = (src_seg == SW'(SEGS-1)) ? '0 : src_seg + 1'b1;
  wire [SW-1:0] dst_nxt = (dst_seg == SW'(SEGS-1)) ? '0 : dst_seg + 1'b1;

  logic [WW-1:0] src_word;
  always_comb begin
    case (ps_a)
      SEL_CMP: src_word = cmp_q;
      SEL_M1:  src_word = m1_q[bank];
      SEL_M2:  src_word = m2_q;
      default: src_word = mem_q[adr_a];
    endcase
  end
  wire [DW-1:0] src_seg_data = src_word[int'(src_seg)*DW +: DW];

  logic [DW-1:0] status;
  always_comb begin
    status = '0;
    status[SW-1:0]          = src_seg;
    status[2*SW-1:SW]       = dst_seg;
    status[2*SW]            = bank;
    status[2*SW+2:2*SW+1]   = ps_a;
    status[2*SW+4:2*SW+3]   = pd_a;
  end

  logic [DW-1:0] ovr_rd;
  always_comb begin
    case (tco_tgt)
      3'd0:    ovr_rd = ctl_q[bank];
      3'd1:    ovr_rd = page_q;
      3'd2:    ovr_rd = sctl_q[bank];
      3'd3:    ovr_rd = DW'(adr_a);
      3'd4:    ovr_rd = nfa_q;
      3'd5:    ovr_rd = dsel_q;
      3'd6:    ovr_rd = DW'(ps_a);
      default: ovr_rd = DW'(pd_a);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank     <= 1'b0;
      src_seg  <= '0;
      dst_seg  <= '0;
      tco_pend <= 1'b0;
      tco_tgt  <= '0;
      page_q   <= '0;
      nfa_q    <= '0;
      dsel_q   <= '0;
      for (int b = 0; b < 2; b++) begin
        ps_q[b]   <= SEL_CMP;
        pd_q[b]   <= SEL_CMP;
        ctl_q[b]  <= '0;
        sctl_q[b] <= '0;
        adr_q[b]  <= '0;
      end
    end else begin
      if (dwr) dst_seg <= dst_nxt;
      if (drd) src_seg <= src_nxt;
      if (crd) tco_pend <= 1'b0;
      if (cwr && tco_pend) begin
        tco_pend <= 1'b0;
        case (tco_tgt)
          3'd0:    ctl_q[bank]  <= din;
          3'd1:    page_q       <= din;
          3'd2:    sctl_q[bank] <= din;
          3'd3:    adr_q[bank]  <= din[AW-1:0];
          3'd4:    nfa_q        <= din;
          3'd5:    dsel_q       <= din;
          default: ;
        endcase
      end
      if (instr) begin
        case (op)
          OP_SPS: begin ps_q[bank] <= din[1:0]; src_seg <= '0; end
          OP_SPD: begin pd_q[bank] <= din[1:0]; dst_seg <= '0; end
          OP_TCO: begin tco_pend <= 1'b1; tco_tgt <= din[2:0]; end
          OP_SFG: begin bank <= 1'b0; src_seg <= '0; dst_seg <= '0; end
          OP_SBG: begin bank <= 1'b1; src_seg <= '0; dst_seg <= '0; end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q <= '0;
      m2_q  <= '0;
      for (int b = 0; b < 2; b++) m1_q[b] <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (dwr) begin
      case (pd_a)
        SEL_CMP: cmp_q[int'(dst_seg)*DW +: DW]        <= din;
        SEL_M1:  m1_q[bank][int'(dst_seg)*DW +: DW]   <= din;
        SEL_M2:  m2_q[int'(dst_seg)*DW +: DW]         <= din;
        default: mem_q[adr_a][int'(dst_seg)*DW +: DW] <= din;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   dout <= '0;
    else if (crd) dout <= tco_pend ? ovr_rd : status;
    else if (drd) dout <= src_seg_data;
  end
endmodule

// File: rtl/seg_route_port_chk.sv
module seg_route_port_chk #(
  parameter int DW   = 16,
  parameter int SEGS = 4,
  parameter int SW   = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce,
  input logic          we,
  input logic          cmd,
  input logic [DW-1:0] din,
  input logic [SW-1:0] src_seg,
  input logic [SW-1:0] dst_seg,
  input logic          tco_pend,
  input logic          bank,
  input logic [1:0]    ps_a,
  input logic [1:0]    pd_a
);
  AST_DST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && we && !cmd) |=> dst_seg == (($past(dst_seg) == SW'(SEGS-1)) ? SW'(0) : SW'($past(dst_seg) + 1'b1))); // R3
  AST_SRC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && !we && !cmd) |=> src_seg == (($past(src_seg) == SW'(SEGS-1)) ? SW'(0) : SW'($past(src_seg) + 1'b1))); // R3
  AST_OVR_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && cmd && tco_pend) |=> !tco_pend); // R6
  AST_DATA_KEEPS_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && !cmd && tco_pend) |=> tco_pend); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> $stable(ps_a) && $stable(pd_a) && $stable(bank) && $stable(src_seg)
            && $stable(dst_seg) && $stable(tco_pend)); // R11
  AST_SPS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && we && cmd && !tco_pend && din[DW-1 -: 4] == 4'd1) |=> src_seg == '0); // R5
  AST_BANK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bank) |-> (src_seg == '0 && dst_seg == '0)); // R9
endmodule

bind seg_route_port seg_route_port_chk #(.DW(DW), .SEGS(SEGS), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce(ce), .we(we), .cmd(cmd), .din(din),
  .src_seg(src_seg), .dst_seg(dst_seg), .tco_pend(tco_pend), .bank(bank),
  .ps_a(ps_a), .pd_a(pd_a)
);

// File: tb/tb_seg_route_port.sv
module tb_seg_route_port;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, ce = 1'b0, we = 1'b0, cmd = 1'b0;
  logic [15:0] din = '0;
  logic [15:0] dout;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  seg_route_port dut (.clk(clk), .rst_n(rst_n), .ce(ce), .we(we), .cmd(cmd), .din(din), .dout(dout));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] st(int src, int dst, int bnk, int ps, int pd);
    return 16'((pd << 7) | (ps << 5) | (bnk << 4) | (dst << 2) | src);
  endfunction
  function automatic logic [15:0] ins(int op, int arg);
    return 16'((op << 12) | arg);
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(logic w, logic c, logic [15:0] d);
    @(negedge clk); ce = 1'b1; we = w; cmd = c; din = d;
    @(negedge clk); ce = 1'b0; we = 1'b0; cmd = 1'b0; din = '0;
  endtask
  task automatic cw(logic [15:0] d); cyc(1'b1, 1'b1, d); endtask
  task automatic dw(logic [15:0] d); cyc(1'b1, 1'b0, d); endtask
  task automatic cr(output logic [15:0] q); cyc(1'b0, 1'b1, '0); q = dout; endtask
  task automatic dr(output logic [15:0] q); cyc(1'b0, 1'b0, '0); q = dout; endtask
  task automatic ovr_wr(int tgt, logic [15:0] d); cw(ins(3, tgt)); cw(d); endtask
  task automatic ovr_rd(int tgt, output logic [15:0] q); cw(ins(3, tgt)); cr(q); endtask

  task automatic do_reset();
    rst_n = 1'b0; repeat (3) @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_reset();
    logic [15:0] q;
    do_reset();
    cr(q);           chk("R1 status", q, '0);
    ovr_rd(6, q);    chk("R1 source", q, 16'd0);
    ovr_rd(7, q);    chk("R1 destination", q, 16'd0);
    cr(q);           chk("R1 default read after override", q, '0);
  endtask

  task automatic t_segments();
    logic [15:0] q;
    do_reset();
    dw(16'h1111); dw(16'h2222); dw(16'h3333); dw(16'h4444);
    for (int k = 0; k < 4; k++) begin
      dr(q); chk("R2 comparand segment", q, 16'(17'h1111 * (k + 1)));
    end
    cw(ins(2, 2)); cw(ins(1, 2));
    dw(16'hA0A0); dw(16'hB1B1); dw(16'hC2C2); dw(16'hD3D3);
    dr(q); chk("R2 mask2 seg0", q, 16'hA0A0);
    dr(q); chk("R2 mask2 seg1", q, 16'hB1B1);
    dr(q); chk("R2 mask2 seg2", q, 16'hC2C2);
    dr(q); chk("R2 mask2 seg3", q, 16'hD3D3);
  endtask

  task automatic t_counters();
    logic [15:0] q;
    do_reset();
    dw(16'h0001);
    cr(q); chk("R3 dst step", q, st(0, 1, 0, 0, 0));
    dw(16'h0002); dw(16'h0003);
    cr(q); chk("R3 dst at 3", q, st(0, 3, 0, 0, 0));
    dw(16'h0004);
    cr(q); chk("R3 dst wrap", q, st(0, 0, 0, 0, 0));
    dr(q); dr(q);
    cr(q); chk("R3 src step only", q, st(2, 0, 0, 0, 0));
    dr(q); dr(q);
    cr(q); chk("R3 src wrap", q, st(0, 0, 0, 0, 0));
  endtask

  task automatic t_sticky();
    logic [15:0] q;
    do_reset();
    cw(ins(2, 1));
    cr(q); chk("R4 dest only", q, st(0, 0, 0, 0, 1));
    cw(ins(1, 3));
    cr(q); chk("R4 source independent", q, st(0, 0, 0, 3, 1));
    dw(16'h7777); dr(q); cw(ins(0, 0));
    cr(q); chk("R4 selections hold", q, st(1, 1, 0, 3, 1));
    ovr_rd(6, q); chk("R4 source readback", q, 16'd3);
  endtask

  task automatic t_clear();
    logic [15:0] q;
    do_reset();
    dw(16'h1); dw(16'h2); dr(q); dr(q); dr(q);
    cr(q); chk("R5 before", q, st(3, 2, 0, 0, 0));
    cw(ins(2, 0));
    cr(q); chk("R5 dst cleared src kept", q, st(3, 0, 0, 0, 0));
    cw(ins(1, 0));
    cr(q); chk("R5 src cleared", q, st(0, 0, 0, 0, 0));
  endtask

  task automatic t_override();
    logic [15:0] q;
    do_reset();
    ovr_wr(0, 16'hBEEF);
    cr(q); chk("R6 default read returns", q, '0);
    ovr_rd(0, q); chk("R6 control", q, 16'hBEEF);
    cw(ins(3, 1));
    dw(16'hCAFE); dw(16'hF00D);
    cw(16'h1234);
    ovr_rd(1, q); chk("R6 data cycles keep override", q, 16'h1234);
    cw(ins(1, 0));
    dr(q); chk("R6 data not redirected", q, 16'hCAFE);
    ovr_wr(2, 16'h0F0F); ovr_wr(4, 16'h4444); ovr_wr(5, 16'hFFFF);
    ovr_rd(2, q); chk("R6 segment control", q, 16'h0F0F);
    ovr_rd(4, q); chk("R6 next free", q, 16'h4444);
    ovr_rd(5, q); chk("R6 device select", q, 16'hFFFF);
    cw(ins(2, 2));
    cr(q); chk("R6 decoder after override", q, st(1, 0, 0, 0, 2));
  endtask

  task automatic t_readonly();
    logic [15:0] q;
    do_reset();
    cw(ins(2, 1)); cw(ins(1, 2));
    ovr_wr(7, 16'h0003); ovr_wr(6, 16'h0001);
    ovr_rd(7, q); chk("R7 dest write ignored", q, 16'd1);
    ovr_rd(6, q); chk("R7 source write ignored", q, 16'd2);
  endtask

  task automatic t_banks();
    logic [15:0] q;
    do_reset();
    ovr_wr(0, 16'hAAAA); ovr_wr(1, 16'h0042);
    cw(ins(2, 1)); dw(16'h1010); dw(16'h2020);
    cw(ins(5, 0));
    cr(q); chk("R9 background, counters cleared", q, st(0, 0, 1, 0, 0));
    ovr_rd(0, q); chk("R8 control banked", q, 16'h0000);
    ovr_rd(1, q); chk("R8 page shared", q, 16'h0042);
    ovr_wr(0, 16'h5555);
    cw(ins(2, 1)); cw(ins(1, 1)); dw(16'h9999);
    dr(q); chk("R8 mask1 banked", q, 16'h9999);
    cw(ins(4, 0));
    cr(q); chk("R9 foreground restored", q, st(0, 0, 0, 0, 1));
    ovr_rd(0, q); chk("R8 fg control", q, 16'hAAAA);
    cw(ins(1, 1)); dr(q); chk("R8 fg mask1 seg0", q, 16'h1010);
  endtask

  task automatic t_memory();
    logic [15:0] q;
    do_reset();
    ovr_wr(3, 16'h0003); cw(ins(2, 3));
    for (int k = 0; k < 4; k++) dw(16'(16'h3000 + k));
    cw(ins(5, 0));
    ovr_wr(3, 16'h0005); cw(ins(2, 3));
    for (int k = 0; k < 4; k++) dw(16'(16'h5000 + k));
    ovr_rd(3, q); chk("R10 bg address", q, 16'h0005);
    cw(ins(4, 0)); cw(ins(1, 3));
    for (int k = 0; k < 4; k++) begin
      dr(q); chk("R10 fg entry 3", q, 16'(16'h3000 + k));
    end
    ovr_wr(3, 16'h0005); cw(ins(1, 3));
    dr(q); chk("R10 entry 5 shared memory", q, 16'h5000);
  endtask

  task automatic t_idle();
    logic [15:0] q, last;
    do_reset();
    dw(16'hABCD); dr(last);
    @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      ce = 1'b0; we = i[0]; cmd = i[1]; din = ins(i % 6, i);
      @(negedge clk);
      checks++;
      if (dout !== last) begin
        fails++; $display("FAIL R11 dout changed: actual %h expected %h", dout, last);
      end
    end
    din = '0; we = 1'b0; cmd = 1'b0;
    cr(q); chk("R11 state unchanged", q, st(1, 1, 0, 0, 0));
  endtask

  initial begin
    t_reset();
    t_segments();
    t_counters();
    t_sticky();
    t_clear();
    t_override();
    t_readonly();
    t_banks();
    t_memory();
    t_idle();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule